// File: doc/BRIEF.md
# Debug-Side Control Port Register Block

This block is a small register file that a debugger reaches through the debug access port. It stays reachable whatever the access port protection state is. The other access ports may be blocked, but this one still lets a debugger hold the device in reset, start a full erase of flash, nonvolatile configuration and RAM, poll that erase, and read whether protection is active. It also returns a fixed identification word that is built from parameters.

Requests arrive on a simple single-beat port: valid, write flag, byte offset and write data. Read data comes back registered with a valid strobe one cycle later. The erase is carried out by a memory controller outside this block. The block raises a request, holds it until the controller reports completion, and then emits a one-cycle completion pulse. Protection logic elsewhere uses that pulse to clear its stored hardware-disable setting.

Top module: `dbg_ctl_port`

## Requirements
- R1: After a synchronous active-low reset, `dev_reset_hold`, `erase_req`, `erase_complete` and `rd_valid` are 0 and `rd_data` is 0.
- R2: A write to offset 0x000 sets `dev_reset_hold` to write-data bit 0 from the next cycle on, and the bit stays until the next write there. Bits 31:1 of the write data are ignored. A read of 0x000 returns the bit in bit 0.
- R3: A write to offset 0x004 with data bit 0 = 1 makes `erase_req` high from the next cycle. A write with bit 0 = 0 starts nothing. Offset 0x004 is write-only and reads as 0.
- R4: A read of offset 0x008 returns 1 in bit 0 while an erase is in progress and 0 when ready.
- R5: `erase_req` stays high until `erase_done` is sampled high. A further erase trigger while busy is ignored and does not cause a second erase.
- R6: When `erase_done` is sampled high during an erase, `erase_req` is low and `erase_complete` is high in the following cycle, for exactly one cycle. `erase_done` while idle has no effect.
- R7: A read of offset 0x00C returns bit 0 = 0 when `prot_active` is 1 (protection enabled) and bit 0 = 1 when `prot_active` is 0.
- R8: A read of offset 0x0FC returns 0x02880000 with the default parameters. The fields are revision in bits 31:28, continuation code in 27:24, identity code in 23:17, class in 16:13 (0x8 memory access port, 0x0 undefined) and port ID in 7:0.
- R9: Reads of any other offset return 0. Writes to read-only or unmapped offsets change no state.
- R10: Every register behaves identically whatever the level of `prot_active`.
- R11: A read request makes `rd_valid` high for one cycle in the next cycle, with `rd_data` valid in that same cycle. Writes never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 32 | Read data |
| prot_active | input | 1 | 1 while access port protection is enabled |
| dev_reset_hold | output | 1 | Holds the device in reset while high |
| erase_req | output | 1 | Erase request to the memory controller |
| erase_done | input | 1 | Memory controller reports the erase finished |
| erase_complete | output | 1 | One-cycle pulse when an erase finishes |

## Verification
A stuck or lost busy flag shows up within one cycle: `erase_req` either drops before `erase_done` or fails to rise after a trigger. The next status read at 0x008 then disagrees with it. A decode fault appears on the first read sweep over all 256 offsets, either as nonzero data at an unmapped offset or as a read-only write that changes `dev_reset_hold` or starts an erase. A completion fault shows up as an `erase_complete` pulse that is missing, extended or spurious, in the cycle after `erase_done`.

// File: rtl/dbg_ctl_pkg.sv
// Shared constants and helpers for the debug control port.
// Assumes a 32-bit register data path.
package dbg_ctl_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NREG     = 5;
    // register slot indices used by the decoder and read mux
    localparam int unsigned IX_HOLD  = 0;
    localparam int unsigned IX_ERASE = 1;
    localparam int unsigned IX_STAT  = 2;
    localparam int unsigned IX_PROT  = 3;
    localparam int unsigned IX_IDENT = 4;

    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_BUSY = 1'b1} seq_state_t;

    // Assemble the identification word from its fields.
    function automatic logic [DATA_W-1:0] make_ident(
        input logic [3:0] rev,
        input logic [3:0] cont,
        input logic [6:0] ident,
        input logic [3:0] cls,
        input logic [7:0] apid
    );
        logic [DATA_W-1:0] w;
        w          = '0;
        w[31:28]   = rev;
        w[27:24]   = cont;
        w[23:17]   = ident;
        w[16:13]   = cls;
        w[7:0]     = apid;
        return w;
    endfunction
endpackage

// File: rtl/dbg_ctl_decode.sv
// Offset decoder: compares the request offset with each register slot
// and reports one-hot hits plus qualified write strobes.
// Assumes offsets are distinct; unmatched offsets give an all-zero hit vector.
module dbg_ctl_decode
    import dbg_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFS_HOLD  = 8'h00,
    parameter logic [ADDR_W-1:0] OFS_ERASE = 8'h04,
    parameter logic [ADDR_W-1:0] OFS_STAT  = 8'h08,
    parameter logic [ADDR_W-1:0] OFS_PROT  = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_IDENT = 8'hFC
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NREG-1:0]   hit,
    output logic              rd_en,
    output logic              wr_hold,
    output logic              wr_erase
);
    localparam logic [ADDR_W-1:0] OFS_TAB [NREG] =
        '{OFS_HOLD, OFS_ERASE, OFS_STAT, OFS_PROT, OFS_IDENT};

    // one comparator per register slot
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = req_valid && (req_addr == OFS_TAB[g]);
    end

    // qualify strobes by direction; only two slots are writable
    always_comb begin
        rd_en    = req_valid && !req_write;
        wr_hold  = req_write && hit[IX_HOLD];
        wr_erase = req_write && hit[IX_ERASE];
    end
endmodule

// File: rtl/dbg_ctl_erase_seq.sv
// Erase-all sequencer: idle/busy handshake toward the memory controller.
// Assumes erase_done is only meaningful while a request is outstanding.
module dbg_ctl_erase_seq
    import dbg_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic erase_done,
    output logic busy,
    output logic erase_complete
);
    seq_state_t state;

    // advance the handshake state and generate the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= SEQ_IDLE;
            erase_complete <= 1'b0;
        end else begin
            erase_complete <= 1'b0;
            case (state)
                SEQ_IDLE: if (start) state <= SEQ_BUSY;
                SEQ_BUSY: if (erase_done) begin
                    state          <= SEQ_IDLE;
                    erase_complete <= 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy = (state == SEQ_BUSY);

    AST_ERASE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R3
    AST_ERASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !erase_done) |=> busy); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_complete |=> !erase_complete); // R6
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_complete |-> ($past(busy) && $past(erase_done) && !busy)); // R6
endmodule

// File: rtl/dbg_ctl_rdmux.sv
// Registered read multiplexer: returns the selected register one cycle
// after a read request. Assumes the hit vector is one-hot or zero.
module dbg_ctl_rdmux
    import dbg_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [NREG-1:0]   hit,
    input  logic [DATA_W-1:0] val [NREG],
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] masked [NREG];
    logic [DATA_W-1:0] merged;

    // gate every slot by its hit bit
    for (genvar g = 0; g < NREG; g++) begin : g_mask
        assign masked[g] = hit[g] ? val[g] : '0;
    end

    // OR the gated slots; no hit gives zero
    always_comb begin
        merged = '0;
        for (int i = 0; i < NREG; i++) merged = merged | masked[i];
    end

    // capture the read result and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? merged : '0;
        end
    end

    AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (hit == '0)) |=> (rd_data == '0)); // R9
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R9
endmodule

// File: rtl/dbg_ctl_port.sv
// Debug control port top: reset-hold bit, erase trigger and status,
// protection status and identification, reachable independent of protection.
// Assumes single-beat accesses and an external memory controller for erase.
module dbg_ctl_port
    import dbg_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [3:0]  ID_REV   = 4'h0,
    parameter logic [3:0]  ID_CONT  = 4'h2,
    parameter logic [6:0]  ID_CODE  = 7'h44,
    parameter logic [3:0]  ID_CLASS = 4'h0,
    parameter logic [7:0]  ID_APID  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              prot_active,
    output logic              dev_reset_hold,
    output logic              erase_req,
    input  logic              erase_done,
    output logic              erase_complete
);
    localparam logic [DATA_W-1:0] IDENT_WORD =
        make_ident(ID_REV, ID_CONT, ID_CODE, ID_CLASS, ID_APID);

    logic [NREG-1:0]   hit;
    logic              rd_en, wr_hold, wr_erase;
    logic              busy;
    logic [DATA_W-1:0] val [NREG];

    dbg_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr[ADDR_W-1:0]),
        .hit       (hit),
        .rd_en     (rd_en),
        .wr_hold   (wr_hold),
        .wr_erase  (wr_erase)
    );

    // hold the device in reset while the stored bit is set
    always_ff @(posedge clk) begin
        if (!rst_n)       dev_reset_hold <= 1'b0;
        else if (wr_hold) dev_reset_hold <= req_wdata[0];
    end

    dbg_ctl_erase_seq u_erase (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (wr_erase && req_wdata[0]),
        .erase_done     (erase_done),
        .busy           (busy),
        .erase_complete (erase_complete)
    );

    assign erase_req = busy;

    // readable view of each slot; the erase trigger is write-only
    always_comb begin
        val[IX_HOLD]  = {{(DATA_W-1){1'b0}}, dev_reset_hold};
        val[IX_ERASE] = '0;
        val[IX_STAT]  = {{(DATA_W-1){1'b0}}, busy};
        val[IX_PROT]  = {{(DATA_W-1){1'b0}}, !prot_active};
        val[IX_IDENT] = IDENT_WORD;
    end

    dbg_ctl_rdmux u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .hit      (hit),
        .val      (val),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hold |=> (dev_reset_hold == $past(req_wdata[0]))); // R2
    AST_HOLD_UPPER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && (req_wdata[DATA_W-1:1] != '0)) |=> (dev_reset_hold == $past(req_wdata[0]))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hold |=> $stable(dev_reset_hold)); // R9
    AST_NO_RD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rd_valid); // R11
endmodule

// File: tb/dbg_ctl_port_tb.sv
// Self-checking bench: offset sweeps, write sweeps and erase handshakes.
module dbg_ctl_port_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        prot_active;
    logic        dev_reset_hold, erase_req, erase_done, erase_complete;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dbg_ctl_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .prot_active(prot_active),
        .dev_reset_hold(dev_reset_hold),
        .erase_req(erase_req), .erase_done(erase_done),
        .erase_complete(erase_complete)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected read value from the requirements
    function automatic logic [31:0] exp_read(input int a, input bit hold, input bit busy, input bit prot);
        case (a)
            8'h00:   return {31'b0, hold};        // R2
            8'h04:   return 32'h0;                // R3
            8'h08:   return {31'b0, busy};        // R4
            8'h0C:   return {31'b0, !prot};       // R7
            8'hFC:   return (32'h0 << 28) | (32'h2 << 24) | (32'h44 << 17) | (32'h0 << 13); // R8
            default: return 32'h0;                // R9
        endcase
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    initial begin
        logic [31:0] d;
        logic v;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; prot_active = 1'b1; erase_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 hold", {31'b0, dev_reset_hold}, 32'h0);
        check("R1 erase_req", {31'b0, erase_req}, 32'h0);
        check("R1 complete", {31'b0, erase_complete}, 32'h0);
        check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);

        // R8 R9 R10 R7 R2: full offset sweep for each protection level and hold value
        for (int p = 0; p < 2; p++) begin
            for (int h = 0; h < 2; h++) begin
                prot_active = p[0];
                do_write(8'h00, h[0] ? 32'hFFFF_FFFF : 32'hFFFF_FFFE); // R2 upper bits ignored
                check("R2 hold pin", {31'b0, dev_reset_hold}, {31'b0, h[0]});
                for (int a = 0; a < 256; a++) begin
                    do_read(a[7:0], d, v);
                    check("R11 rd_valid", {31'b0, v}, 32'h1);
                    check("R10 read sweep", d, exp_read(a, h[0], 1'b0, p[0]));
                end
            end
        end
        do_write(8'h00, 32'h0);
        check("R2 release", {31'b0, dev_reset_hold}, 32'h0);
        @(negedge clk);
        check("R11 no strobe after write", {31'b0, rd_valid}, 32'h0);

        // R9: writes to read-only and unmapped offsets change nothing
        for (int a = 0; a < 256; a++) begin
            if (a == 0 || a == 4) continue;
            do_write(a[7:0], 32'hFFFF_FFFF);
            check("R9 hold untouched", {31'b0, dev_reset_hold}, 32'h0);
            check("R9 no erase", {31'b0, erase_req}, 32'h0);
        end
        do_read(8'hFC, d, v);
        check("R9 ident unchanged", d, 32'h0288_0000);

        // R3: writing 0 (or bit0 clear) does not start an erase
        do_write(8'h04, 32'h0);
        check("R3 zero no start", {31'b0, erase_req}, 32'h0);
        do_write(8'h04, 32'h2);
        check("R3 bit0 clear no start", {31'b0, erase_req}, 32'h0);
        // R6: done while idle has no effect
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        check("R6 idle done no pulse", {31'b0, erase_complete}, 32'h0);

        // erase handshake with both protection levels
        for (int p = 0; p < 2; p++) begin
            prot_active = p[0];
            do_write(8'h04, 32'h1);
            check("R3 start", {31'b0, erase_req}, 32'h1);
            do_read(8'h08, d, v);
            check("R4 busy", d, 32'h1);
            do_read(8'h04, d, v);
            check("R3 write-only read", d, 32'h0);
            do_write(8'h04, 32'h1);  // R5 ignored retrigger
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check("R5 held", {31'b0, erase_req}, 32'h1);
            end
            erase_done = 1'b1;
            @(negedge clk);
            erase_done = 1'b0;
            check("R6 req drop", {31'b0, erase_req}, 32'h0);
            check("R6 pulse", {31'b0, erase_complete}, 32'h1);
            @(negedge clk);
            check("R6 pulse width", {31'b0, erase_complete}, 32'h0);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check("R5 no second erase", {31'b0, erase_req}, 32'h0);
            end
            do_read(8'h08, d, v);
            check("R4 ready", d, 32'h0);
        end

        // R1: reset in the middle of an erase returns to idle
        do_write(8'h04, 32'h1);
        do_write(8'h00, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset mid erase req", {31'b0, erase_req}, 32'h0);
        check("R1 reset hold", {31'b0, dev_reset_hold}, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule